// File: doc/BRIEF.md
# Decoupled Tag/Data Instruction Cache

This block is a set-associative instruction cache. The tag lookup and the data read are two separate pipeline stages, and a short FIFO of pending accesses joins them. A fetch address enters the tag stage through a ready/valid handshake. One cycle later the tag stage compares the address against every way of its set. On a hit it records the matching way. On a miss it takes a round-robin victim, writes the new tag, marks the line as awaiting fill and sends a line refill request to the next memory level. In both cases it pushes a queue entry that carries the line slot (way and set), the word offset and a pending flag.

The data stage serves entries from the queue head. Each one costs a read of a single line slot of the data array, so one way is enabled and not the whole set. When the head entry's line is still awaiting its fill, the data stage waits. The tag stage does not wait: it keeps looking up later addresses while earlier misses are being fetched, so each miss acts as a prefetch for the access queued behind it. Refill responses carry back the slot identifier of their request and may come back in any order. A redirect flush discards the queued and in-flight accesses. Refills that were already requested still write the array.

Top module: `split_icache`

## Requirements
- R1: Every accepted fetch address produces exactly one response (unless flushed). Its data is the 32-bit word at that address, taken from the line that the refill response delivered. Word i of the line sits in bits [32*i+31 : 32*i], and the word index is address bits [4:2].
- R2: Responses come out in the order in which their fetch addresses were accepted, even when refill responses return in a different order from the requests.
- R3: On a tag miss, a refill request for the line-aligned address (low 5 bits zero) is raised in the cycle after the lookup, before the access reaches the data stage. The tag stage then goes on accepting further addresses while that refill is outstanding.
- R4: An address whose line has already been allocated and is still awaiting its fill counts as a tag hit and raises no second refill request. No two outstanding refill requests name the same line.
- R5: While the entry at the queue head refers to a line awaiting its fill, the data stage holds that entry and gives no response for it until the matching refill response arrives.
- R6: With the default depth of 4, holding refills back lets at most 5 fetches be accepted (4 queued and 1 held in the tag stage). req_ready then stays low while the queue is full.
- R7: A flush cycle empties the queue and drops the lookup and data read in flight, so none of those accesses ever responds. Refills already requested still complete and fill the array, so a later fetch of such a line hits with no new refill request.
- R8: In the cycle after reset, req_ready is high and rsp_valid and rf_req_valid are low.
- R9: A victim way whose line is awaiting its fill, or that a queued entry still refers to, is not replaced. The missing lookup waits in the tag stage instead, so responses never return data from a replaced line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch address valid |
| req_ready | output | 1 | Tag stage can take the fetch address |
| req_addr | input | 32 | Fetch byte address (word aligned) |
| flush | input | 1 | Redirect: drop all queued and in-flight accesses |
| rf_req_valid | output | 1 | Refill request pulse |
| rf_req_addr | output | 32 | Line-aligned address to fetch |
| rf_req_id | output | 8 | Slot identifier that the response must echo |
| rf_rsp_valid | input | 1 | Refill response valid |
| rf_rsp_id | input | 8 | Slot identifier of the returning line |
| rf_rsp_line | input | 256 | Whole line, word 0 in the low bits |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | 32 | Instruction word |

## Verification
The assertions check on every cycle the relations between the stages. A miss lookup is always followed by a refill request, and every refill request has such a miss as its cause. A full queue stays full while nothing is popped. A pending head entry stays put until its own refill arrives. A popped entry becomes a response two cycles later. A flush clears both the queue and the response. Data correctness, response order under out-of-order refill return, the absence of duplicate refills, the five-deep acceptance limit and the flush fill-through can only be shown by the bench's scenarios: directed cases with refills held back or returned last-first, then a long random run over a small pool of conflicting lines with occasional flushes.

// File: rtl/split_icache_pkg.sv
package split_icache_pkg;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_WAYS       = 4;
  localparam int unsigned DEF_SETS       = 64;
  localparam int unsigned DEF_LINE_BYTES = 32;
  localparam int unsigned DEF_WORD_W     = 32;
  localparam int unsigned DEF_QDEPTH     = 4;

  function automatic int unsigned slot_id_w(input int unsigned ways, input int unsigned sets);
    return $clog2(ways) + $clog2(sets);
  endfunction
endpackage

// File: rtl/split_icache_tag.sv
module split_icache_tag #(
  parameter int unsigned ADDR_W     = split_icache_pkg::DEF_ADDR_W,
  parameter int unsigned WAYS       = split_icache_pkg::DEF_WAYS,
  parameter int unsigned SETS       = split_icache_pkg::DEF_SETS,
  parameter int unsigned LINE_BYTES = split_icache_pkg::DEF_LINE_BYTES,
  parameter int unsigned WORD_W     = split_icache_pkg::DEF_WORD_W,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned ID_W   = WAY_W + SET_W,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned BYTE_W = $clog2(WORD_W / 8),
  localparam int unsigned WOFF_W = OFF_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              q_full,
  input  logic              q_ref_hit,
  output logic [ID_W-1:0]   q_ref_id,
  output logic              push_valid,
  output logic [ID_W-1:0]   push_id,
  output logic [WOFF_W-1:0] push_woff,
  output logic              push_pend,
  output logic              tag_miss,
  input  logic              rf_rsp_valid,
  input  logic [ID_W-1:0]   rf_rsp_id,
  output logic              rf_req_valid,
  output logic [ADDR_W-1:0] rf_req_addr,
  output logic [ID_W-1:0]   rf_req_id
);
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int unsigned NLINES = WAYS * SETS;

  logic              t_valid;
  logic [ADDR_W-1:0] t_addr;
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic              tag_v  [SETS][WAYS];
  logic [WAY_W-1:0]  rr_ptr [SETS];
  logic [NLINES-1:0] line_pend;

  logic [SET_W-1:0]  l_set;
  logic [TAG_W-1:0]  l_tag;
  logic [WAYS-1:0]   hit_vec;
  logic              l_hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  victim;
  logic [ID_W-1:0]   victim_id;
  logic              victim_busy;
  logic              can_go;
  logic [WAY_W-1:0]  use_way;

  assign l_set = t_addr[OFF_W +: SET_W];
  assign l_tag = t_addr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = tag_v[l_set][w] && (tag_q[l_set][w] == l_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign l_hit       = |hit_vec;
  assign victim      = rr_ptr[l_set];
  assign victim_id   = {victim, l_set};
  assign q_ref_id    = victim_id;
  assign victim_busy = line_pend[victim_id] || q_ref_hit;
  assign can_go      = t_valid && !flush && !q_full && (l_hit || !victim_busy);
  assign use_way     = l_hit ? hit_way : victim;

  assign push_valid = can_go;
  assign push_id    = {use_way, l_set};
  assign push_woff  = t_addr[BYTE_W +: WOFF_W];
  assign push_pend  = !l_hit ||
                      (line_pend[push_id] && !(rf_rsp_valid && rf_rsp_id == push_id));
  assign tag_miss   = can_go && !l_hit;
  assign req_ready  = !flush && (!t_valid || can_go);

  always_ff @(posedge clk) begin
    if (rst) begin
      t_valid      <= 1'b0;
      t_addr       <= '0;
      rf_req_valid <= 1'b0;
      rf_req_addr  <= '0;
      rf_req_id    <= '0;
      line_pend    <= '0;
      for (int s = 0; s < SETS; s++) begin
        rr_ptr[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_v[s][w] <= 1'b0;
      end
    end else begin
      if (flush) begin
        t_valid <= 1'b0;
      end else if (req_valid && req_ready) begin
        t_valid <= 1'b1;
        t_addr  <= req_addr;
      end else if (can_go) begin
        t_valid <= 1'b0;
      end
      rf_req_valid <= tag_miss;
      rf_req_id    <= push_id;
      rf_req_addr  <= {t_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      if (rf_rsp_valid) line_pend[rf_rsp_id] <= 1'b0;
      if (tag_miss) begin
        line_pend[victim_id]  <= 1'b1;
        tag_v[l_set][victim]  <= 1'b1;
        rr_ptr[l_set] <= (victim == WAY_W'(WAYS - 1)) ? '0 : victim + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tag_miss) tag_q[l_set][victim] <= l_tag;
  end
endmodule

// File: rtl/split_icache_fifo.sv
module split_icache_fifo #(
  parameter int unsigned DEPTH  = split_icache_pkg::DEF_QDEPTH,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned WOFF_W = 3,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic [WOFF_W-1:0] push_woff,
  input  logic              push_pend,
  input  logic              pop,
  input  logic              rf_rsp_valid,
  input  logic [ID_W-1:0]   rf_rsp_id,
  input  logic [ID_W-1:0]   ref_id,
  output logic              ref_hit,
  output logic              full,
  output logic              head_valid,
  output logic [ID_W-1:0]   head_id,
  output logic [WOFF_W-1:0] head_woff,
  output logic              head_pend
);
  logic              e_v    [DEPTH];
  logic              e_pend [DEPTH];
  logic [ID_W-1:0]   e_id   [DEPTH];
  logic [WOFF_W-1:0] e_woff [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DEPTH-1:0]  ref_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ref
    assign ref_vec[i] = e_v[i] && (e_id[i] == ref_id);
  end

  assign ref_hit    = |ref_vec;
  assign full       = e_v[wr_ptr];
  assign head_valid = e_v[rd_ptr];
  assign head_id    = e_id[rd_ptr];
  assign head_woff  = e_woff[rd_ptr];
  assign head_pend  = e_pend[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_v[i]    <= 1'b0;
        e_pend[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rf_rsp_valid && e_id[i] == rf_rsp_id) e_pend[i] <= 1'b0;
      end
      if (pop) begin
        e_v[rd_ptr] <= 1'b0;
        rd_ptr      <= bump(rd_ptr);
      end
      if (push) begin
        e_v[wr_ptr]    <= 1'b1;
        e_pend[wr_ptr] <= push_pend;
        wr_ptr         <= bump(wr_ptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      e_id[wr_ptr]   <= push_id;
      e_woff[wr_ptr] <= push_woff;
    end
  end
endmodule

// File: rtl/split_icache_data.sv
module split_icache_data #(
  parameter int unsigned NLINES = 256,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned WOFF_W = 3,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned LINE_W = WORD_W << WOFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              head_valid,
  input  logic [ID_W-1:0]   head_id,
  input  logic [WOFF_W-1:0] head_woff,
  input  logic              head_pend,
  output logic              pop,
  input  logic              rf_rsp_valid,
  input  logic [ID_W-1:0]   rf_rsp_id,
  input  logic [LINE_W-1:0] rf_rsp_line,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  logic [LINE_W-1:0] mem [NLINES];
  logic [LINE_W-1:0] rd_line;
  logic              rd_valid;
  logic [WOFF_W-1:0] rd_woff;

  assign pop = head_valid && !head_pend && !flush;

  always_ff @(posedge clk) begin
    if (rf_rsp_valid) mem[rf_rsp_id] <= rf_rsp_line;
    if (pop) rd_line <= mem[head_id];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_valid  <= 1'b0;
      rd_woff   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rd_valid  <= pop;
      rd_woff   <= head_woff;
      rsp_valid <= rd_valid;
      rsp_data  <= rd_line[rd_woff * WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/split_icache.sv
module split_icache #(
  parameter int unsigned ADDR_W     = split_icache_pkg::DEF_ADDR_W,
  parameter int unsigned WAYS       = split_icache_pkg::DEF_WAYS,
  parameter int unsigned SETS       = split_icache_pkg::DEF_SETS,
  parameter int unsigned LINE_BYTES = split_icache_pkg::DEF_LINE_BYTES,
  parameter int unsigned WORD_W     = split_icache_pkg::DEF_WORD_W,
  parameter int unsigned QDEPTH     = split_icache_pkg::DEF_QDEPTH,
  localparam int unsigned ID_W   = split_icache_pkg::slot_id_w(WAYS, SETS),
  localparam int unsigned LINE_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              flush,
  output logic              rf_req_valid,
  output logic [ADDR_W-1:0] rf_req_addr,
  output logic [ID_W-1:0]   rf_req_id,
  input  logic              rf_rsp_valid,
  input  logic [ID_W-1:0]   rf_rsp_id,
  input  logic [LINE_W-1:0] rf_rsp_line,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  localparam int unsigned WOFF_W = $clog2(LINE_BYTES) - $clog2(WORD_W / 8);
  localparam int unsigned NLINES = WAYS * SETS;

  logic              q_full, q_ref_hit, q_pop;
  logic [ID_W-1:0]   q_ref_id;
  logic              push_valid, push_pend, tag_miss;
  logic [ID_W-1:0]   push_id;
  logic [WOFF_W-1:0] push_woff;
  logic              head_valid, head_pend;
  logic [ID_W-1:0]   head_id;
  logic [WOFF_W-1:0] head_woff;

  split_icache_tag #(
    .ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS),
    .LINE_BYTES(LINE_BYTES), .WORD_W(WORD_W)
  ) u_tag (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .q_full(q_full), .q_ref_hit(q_ref_hit), .q_ref_id(q_ref_id),
    .push_valid(push_valid), .push_id(push_id), .push_woff(push_woff),
    .push_pend(push_pend), .tag_miss(tag_miss),
    .rf_rsp_valid(rf_rsp_valid), .rf_rsp_id(rf_rsp_id),
    .rf_req_valid(rf_req_valid), .rf_req_addr(rf_req_addr), .rf_req_id(rf_req_id)
  );

  split_icache_fifo #(.DEPTH(QDEPTH), .ID_W(ID_W), .WOFF_W(WOFF_W)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush),
    .push(push_valid), .push_id(push_id), .push_woff(push_woff), .push_pend(push_pend),
    .pop(q_pop), .rf_rsp_valid(rf_rsp_valid), .rf_rsp_id(rf_rsp_id),
    .ref_id(q_ref_id), .ref_hit(q_ref_hit), .full(q_full),
    .head_valid(head_valid), .head_id(head_id), .head_woff(head_woff), .head_pend(head_pend)
  );

  split_icache_data #(.NLINES(NLINES), .ID_W(ID_W), .WOFF_W(WOFF_W), .WORD_W(WORD_W)) u_data (
    .clk(clk), .rst(rst), .flush(flush),
    .head_valid(head_valid), .head_id(head_id), .head_woff(head_woff), .head_pend(head_pend),
    .pop(q_pop),
    .rf_rsp_valid(rf_rsp_valid), .rf_rsp_id(rf_rsp_id), .rf_rsp_line(rf_rsp_line),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/split_icache_chk.sv
module split_icache_chk #(
  parameter int unsigned ID_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            rsp_valid,
  input logic            rf_req_valid,
  input logic            rf_rsp_valid,
  input logic [ID_W-1:0] rf_rsp_id,
  input logic            tag_miss,
  input logic            q_full,
  input logic            q_pop,
  input logic            head_valid,
  input logic            head_pend,
  input logic [ID_W-1:0] head_id
);
  p_reset_idle_r8: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !rf_req_valid));

  p_miss_refill_r3: assert property (@(posedge clk) disable iff (rst)
    tag_miss |=> rf_req_valid);

  p_refill_cause_r3: assert property (@(posedge clk) disable iff (rst)
    rf_req_valid |-> $past(tag_miss));

  p_full_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (q_full && !q_pop && !flush) |=> q_full);

  p_stall_pending_r5: assert property (@(posedge clk) disable iff (rst)
    (head_valid && head_pend && !flush && !(rf_rsp_valid && rf_rsp_id == head_id))
      |=> (head_valid && head_pend && $stable(head_id)));

  p_pop_resp_r1: assert property (@(posedge clk) disable iff (rst)
    (q_pop ##1 !flush) |=> rsp_valid);

  p_flush_clear_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!rsp_valid && !head_valid));
endmodule

bind split_icache split_icache_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .rsp_valid(rsp_valid),
  .rf_req_valid(rf_req_valid), .rf_rsp_valid(rf_rsp_valid), .rf_rsp_id(rf_rsp_id),
  .tag_miss(tag_miss), .q_full(q_full), .q_pop(q_pop),
  .head_valid(head_valid), .head_pend(head_pend), .head_id(head_id)
);

// File: tb/split_icache_bench.sv
module split_icache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QDEPTH = 4;
  localparam int LINE_W = 256;
  localparam int ID_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [31:0]       req_addr = '0;
  logic              flush = 1'b0;
  logic              rf_req_valid;
  logic [31:0]       rf_req_addr;
  logic [ID_W-1:0]   rf_req_id;
  logic              rf_rsp_valid = 1'b0;
  logic [ID_W-1:0]   rf_rsp_id = '0;
  logic [LINE_W-1:0] rf_rsp_line = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  split_icache u_split_icache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .flush(flush), .rf_req_valid(rf_req_valid), .rf_req_addr(rf_req_addr), .rf_req_id(rf_req_id),
    .rf_rsp_valid(rf_rsp_valid), .rf_rsp_id(rf_rsp_id), .rf_rsp_line(rf_rsp_line),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int checks = 0;
  int errors = 0;
  int n_refills = 0;
  int n_rsp = 0;

  logic [31:0] exp_a [64];
  int exp_n = 0;

  logic [31:0]     pd_addr [64];
  logic [ID_W-1:0] pd_id   [64];
  int              pd_dly  [64];
  int npend = 0;

  logic hold = 1'b0;
  logic lifo = 1'b0;
  logic drv_valid = 1'b0;
  logic drv_flush = 1'b0;
  logic [31:0] drv_addr = '0;
  logic acc;

  function automatic logic [31:0] word_val(input logic [31:0] a);
    return ((a ^ 32'hA5C3_0F1E) * 32'h0101_0193) + 32'h0000_1357;
  endfunction

  function automatic logic [LINE_W-1:0] line_val(input logic [31:0] la);
    logic [LINE_W-1:0] l;
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = word_val(la + 32'(4 * i));
    return l;
  endfunction

  function automatic logic [31:0] mk(input int tag, input int set, input int word);
    return 32'((tag << 11) | (set << 5) | (word << 2));
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic step();
    @(negedge clk);
    // response side: R1 data, R2 order, R7 no orphan responses
    if (rsp_valid) begin
      n_rsp++;
      chk(exp_n > 0, "R7", "response with nothing outstanding", rsp_data, 32'h0);
      if (exp_n > 0) begin
        chk(rsp_data == word_val({exp_a[0][31:2], 2'b00}), "R2", "response word in order",
            rsp_data, word_val({exp_a[0][31:2], 2'b00}));
        for (int i = 1; i < exp_n; i++) exp_a[i-1] = exp_a[i];
        exp_n--;
      end
    end
    // refill request side: R3 alignment, R4 no duplicate
    if (rf_req_valid) begin
      logic dup;
      dup = 1'b0;
      for (int j = 0; j < npend; j++) if (pd_addr[j] == rf_req_addr) dup = 1'b1;
      chk(!dup, "R4", "duplicate outstanding refill", rf_req_addr, 32'h0);
      chk(rf_req_addr[4:0] == 5'd0, "R3", "refill address line aligned", rf_req_addr,
          {rf_req_addr[31:5], 5'd0});
      n_refills++;
      pd_addr[npend] = rf_req_addr;
      pd_id[npend]   = rf_req_id;
      pd_dly[npend]  = int'($urandom % 8);
      npend++;
    end
    rf_rsp_valid = 1'b0;
    if (!hold && npend > 0) begin
      int k;
      k = lifo ? npend - 1 : int'($urandom % npend);
      if (lifo || pd_dly[k] == 0) begin
        rf_rsp_valid = 1'b1;
        rf_rsp_id    = pd_id[k];
        rf_rsp_line  = line_val(pd_addr[k]);
        for (int i = k + 1; i < npend; i++) begin
          pd_addr[i-1] = pd_addr[i];
          pd_id[i-1]   = pd_id[i];
          pd_dly[i-1]  = pd_dly[i];
        end
        npend--;
      end
    end
    for (int j = 0; j < npend; j++) if (pd_dly[j] > 0) pd_dly[j]--;
    flush = drv_flush;
    if (drv_flush) exp_n = 0;
    req_valid = drv_valid;
    req_addr  = drv_addr;
    #1;
    acc = req_valid && req_ready;
    if (acc) begin
      exp_a[exp_n] = req_addr;
      exp_n++;
    end
  endtask

  task automatic send(input logic [31:0] a);
    drv_valid = 1'b1;
    drv_addr  = a;
    for (int n = 0; n < 200; n++) begin
      step();
      if (acc) break;
    end
    drv_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain();
    hold = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      step();
      if (exp_n == 0 && npend == 0) break;
    end
    idle(4);
    lifo = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int base, idx, rsp0;
    logic [31:0] bp [7];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R8 reset state
    chk(req_ready == 1'b1, "R8", "req_ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R8", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk(rf_req_valid == 1'b0, "R8", "rf_req_valid after reset", 32'(rf_req_valid), 32'h0);

    // R3/R5: several misses issue refills while the data stage is stalled
    hold = 1'b1;
    base = n_refills; rsp0 = n_rsp;
    send(mk(1, 2, 0)); send(mk(1, 3, 5)); send(mk(1, 4, 7));
    idle(8);
    chk(n_refills - base == 3, "R3", "refills issued with no data returned",
        32'(n_refills - base), 32'd3);
    chk(n_rsp == rsp0, "R5", "no response while lines are pending", 32'(n_rsp - rsp0), 32'd0);
    drain();
    chk(n_rsp - rsp0 == 3, "R1", "one response per fetch", 32'(n_rsp - rsp0), 32'd3);

    // R4: same line fetched while awaiting its fill
    hold = 1'b1;
    base = n_refills;
    send(mk(2, 9, 1)); send(mk(2, 9, 6)); send(mk(2, 9, 3));
    idle(6);
    chk(n_refills - base == 1, "R4", "single refill for repeated line", 32'(n_refills - base), 32'd1);
    drain();

    // R6: back-pressure with refills held
    for (int i = 0; i < 7; i++) bp[i] = mk(3, 10 + i, i);
    hold = 1'b1;
    idx = 0;
    for (int n = 0; n < 20; n++) begin
      drv_valid = 1'b1;
      drv_addr  = bp[idx];
      step();
      if (acc) idx++;
    end
    chk(idx == QDEPTH + 1, "R6", "accepted with queue full", 32'(idx), 32'(QDEPTH + 1));
    chk(req_ready == 1'b0, "R6", "req_ready low when full", 32'(req_ready), 32'h0);
    hold = 1'b0;
    while (idx < 7) begin
      drv_addr = bp[idx];
      step();
      if (acc) idx++;
    end
    drv_valid = 1'b0;
    drain();

    // R2: refills returned last-first
    hold = 1'b1;
    send(mk(4, 20, 2)); send(mk(4, 21, 4)); send(mk(4, 22, 6)); send(mk(4, 23, 1));
    idle(6);
    lifo = 1'b1;
    rsp0 = n_rsp;
    drain();
    chk(n_rsp - rsp0 == 4, "R2", "all responses after reversed refills", 32'(n_rsp - rsp0), 32'd4);

    // R7: flush with refills outstanding, then refetch hits
    hold = 1'b1;
    send(mk(5, 30, 0)); send(mk(5, 31, 1)); send(mk(5, 32, 2));
    idle(5);
    drv_flush = 1'b1; step(); drv_flush = 1'b0;
    rsp0 = n_rsp;
    hold = 1'b0;
    idle(40);
    chk(n_rsp == rsp0, "R7", "no response after flush", 32'(n_rsp - rsp0), 32'd0);
    chk(npend == 0, "R7", "issued refills completed", 32'(npend), 32'd0);
    base = n_refills;
    send(mk(5, 30, 4)); send(mk(5, 31, 5)); send(mk(5, 32, 6));
    drain();
    chk(n_refills == base, "R7", "refetch after flush hits", 32'(n_refills - base), 32'd0);
    chk(n_rsp - rsp0 == 3, "R7", "refetch responses", 32'(n_rsp - rsp0), 32'd3);

    // R9 and mixed traffic: random over a small conflicting pool
    drv_addr = mk(1, 0, 0);
    for (int n = 0; n < 4000; n++) begin
      if (acc || !drv_valid)
        drv_addr = mk(int'($urandom % 6) + 8, int'($urandom % 4) * 5, int'($urandom % 8));
      drv_valid = ($urandom % 4) != 0;
      drv_flush = ($urandom % 100) == 0;
      step();
    end
    drv_valid = 1'b0;
    drv_flush = 1'b0;
    drain();
    chk(exp_n == 0, "R9", "every random fetch answered", 32'(exp_n), 32'd0);

    summary();
    $finish;
  end
endmodule